// File: doc/BRIEF.md
# Debug Control Register Bank with Arm Lock

This block is the register file of an on-chip debug unit. It holds one control register and an 8-byte window. The window shows the setup bytes of one of four comparator banks at a time. A 2-bit bank-select field in the control register chooses which bank appears in the window. Software reaches everything through a small synchronous register bus. The bus has an address, a write strobe, write data, a read strobe and registered read data.

Arming the unit freezes its setup. While the arm bit is set, a write can change only three things: the arm bit, the trigger bit and the bank-select field. Writes to the debug-mode and break-enable bits are dropped, and so are all comparator writes. Software can still move the window between banks to read the frozen settings. A write that disarms the unit leaves the mode and break bits as they were, because the lock still applied when that write arrived. A second write is needed to change them. Writing 1 to the trigger bit produces a one-cycle pulse, and that bit always reads as 0. Every comparator byte is driven out in parallel to the matching logic, which lies outside this block.

Top module: `dbg_regbank`

## Requirements
- R1: After reset, every control field, every comparator byte, the trigger pulse and the read data are 0.
- R2: A read of the control register (offset 0x20) returns arm in bit 7, debug mode in bit 4, break enable in bit 3 and bank select in bits 1:0. Bits 6, 5 and 2 read as 0.
- R3: A write to 0x20 with bit 6 set raises trig_pulse for exactly the one cycle after the write edge, whether or not the unit is armed. trig_pulse is 0 at all other times.
- R4: While disarmed, a write to 0x20 loads arm from bit 7, debug mode from bit 4, break enable from bit 3 and bank select from bits 1:0.
- R5: While armed, a write to 0x20 updates arm and bank select only, and debug mode and break enable keep their values. This includes a write that clears arm.
- R6: While disarmed, a write to offset 0x28+k (k = 0..7) stores the byte as byte k of the bank chosen by bank select. Byte k of bank n appears on cmp_regs[n*64 + k*8 +: 8]. Byte 0 is the comparator control byte, 1 is the address extension, 2 and 3 are data high and low, 4 and 5 are address high and low, and 6 and 7 are mask high and low.
- R7: While armed, writes to the window are ignored and cmp_regs does not change.
- R8: A read of 0x28+k returns byte k of the bank chosen by the current bank select, including when the bank select has been changed while armed.
- R9: A read of any address other than 0x20 and 0x28–0x2F returns 0. A write to such an address changes no state.
- R10: Read data is registered. It shows the addressed value in the cycle after the read edge and is 0 in any cycle that follows an edge without a read. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| armed | output | 1 | Arm state |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| dbg_mode | output | 1 | Debug-mode select |
| brk_en | output | 1 | Break enable |
| bank_sel | output | 2 | Comparator bank select |
| cmp_regs | output | 256 | All comparator bytes, four banks of eight |

## Verification
Each result is due on a fixed cycle.

- **Control and comparator state:** A write updates the control outputs and the comparator bytes at the clock edge that captures it. The new value is first visible in the cycle after that edge.
- **Trigger pulse:** trig_pulse is high only during the cycle after the edge that captured the write.
- **Read data:** bus_rdata carries the addressed value only in the cycle after the read edge, and is 0 in the cycle after that unless another read follows.
- **After reset:** the internal reset releases two edges after rst_n rises, so the bench waits several cycles before its first access.

The bench drives each access on a falling edge and samples on the next falling edge, which falls in exactly the cycle where the result is due. It then compares against a bench model that is updated only after the sample.

// File: rtl/dbg_regbank_pkg.sv
package dbg_regbank_pkg;

  // Control register bit positions (fixed by the register layout)
  localparam int unsigned CB_ARM  = 7;
  localparam int unsigned CB_TRG  = 6;
  localparam int unsigned CB_MODE = 4;
  localparam int unsigned CB_BRK  = 3;

  localparam int unsigned SEL_W     = 2;
  localparam int unsigned NUM_BANKS = 1 << SEL_W;

  typedef struct packed {
    logic             arm;
    logic             mode;
    logic             brk;
    logic [SEL_W-1:0] sel;
  } dbg_ctrl_t;

endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output dbg_ctrl_t         ctrl,
  output logic              trig
);

  dbg_ctrl_t ctrl_q, ctrl_d;
  logic      trig_q, trig_d;
  logic      unused_bits;

  assign unused_bits = ^{wdata[DATA_W-1:CB_ARM+1], wdata[5], wdata[2]};

  // next state: lock applies according to arm value before this write
  always_comb begin
    ctrl_d = ctrl_q;
    trig_d = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.arm = wdata[CB_ARM];
      ctrl_d.sel = wdata[SEL_W-1:0];
      trig_d     = wdata[CB_TRG];
      if (!ctrl_q.arm) begin
        ctrl_d.mode = wdata[CB_MODE];
        ctrl_d.brk  = wdata[CB_BRK];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign ctrl = ctrl_q;
  assign trig = trig_q;

endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned WIN_BYTES = 8,
  localparam int unsigned IDX_W    = $clog2(WIN_BYTES),
  localparam int unsigned BANK_W   = WIN_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] regs
);

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
    logic              byte_en;
    logic [DATA_W-1:0] byte_q;

    assign byte_en = wr_en && (wr_idx == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= wdata;
      end
    end

    assign regs[b*DATA_W +: DATA_W] = byte_q;
  end

endmodule

// File: rtl/dbg_rd_mux.sv
module dbg_rd_mux
  import dbg_regbank_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned WIN_BYTES = 8,
  localparam int unsigned IDX_W    = $clog2(WIN_BYTES),
  localparam int unsigned TOT_W    = NUM_BANKS * WIN_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              hit_ctrl,
  input  logic              hit_win,
  input  logic [IDX_W-1:0]  idx,
  input  dbg_ctrl_t         ctrl,
  input  logic [TOT_W-1:0]  cmp_all,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] win_byte, ctrl_byte, rd_d, rd_q;

  always_comb begin
    win_byte = '0;
    for (int n = 0; n < int'(NUM_BANKS); n++) begin
      for (int b = 0; b < int'(WIN_BYTES); b++) begin
        if (ctrl.sel == SEL_W'(n) && idx == IDX_W'(b)) begin
          win_byte = cmp_all[(n*WIN_BYTES + b)*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_comb begin
    ctrl_byte              = '0;
    ctrl_byte[CB_ARM]      = ctrl.arm;
    ctrl_byte[CB_MODE]     = ctrl.mode;
    ctrl_byte[CB_BRK]      = ctrl.brk;
    ctrl_byte[SEL_W-1:0]   = ctrl.sel;
  end

  always_comb begin
    rd_d = '0;
    if (rd_en) begin
      if (hit_ctrl)     rd_d = ctrl_byte;
      else if (hit_win) rd_d = win_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/dbg_regbank.sv
module dbg_regbank
  import dbg_regbank_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 8,
  parameter int unsigned     DATA_W    = 8,
  parameter int unsigned     WIN_BYTES = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] WIN_ADDR  = 'h28,
  localparam int unsigned    IDX_W     = $clog2(WIN_BYTES),
  localparam int unsigned    BANK_W    = WIN_BYTES * DATA_W,
  localparam int unsigned    TOT_W     = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              armed,
  output logic              trig_pulse,
  output logic              dbg_mode,
  output logic              brk_en,
  output logic [SEL_W-1:0]  bank_sel,
  output logic [TOT_W-1:0]  cmp_regs
);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  // address decode
  dbg_ctrl_t        ctrl;
  logic             hit_ctrl, hit_win, wr_ctrl, wr_win;
  logic [IDX_W-1:0] win_idx;

  assign hit_ctrl = (bus_addr == CTRL_ADDR);
  assign hit_win  = (bus_addr[ADDR_W-1:IDX_W] == WIN_ADDR[ADDR_W-1:IDX_W]);
  assign win_idx  = bus_addr[IDX_W-1:0];
  assign wr_ctrl  = bus_wr && hit_ctrl;
  assign wr_win   = bus_wr && hit_win && !ctrl.arm;

  dbg_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata),
    .ctrl    (ctrl),
    .trig    (trig_pulse)
  );

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_win && (ctrl.sel == SEL_W'(n));

    dbg_cmp_bank #(.DATA_W(DATA_W), .WIN_BYTES(WIN_BYTES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr_en  (bank_we),
      .wr_idx (win_idx),
      .wdata  (bus_wdata),
      .regs   (cmp_regs[n*BANK_W +: BANK_W])
    );
  end

  dbg_rd_mux #(.DATA_W(DATA_W), .WIN_BYTES(WIN_BYTES)) u_rd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_en    (bus_rd),
    .hit_ctrl (hit_ctrl),
    .hit_win  (hit_win),
    .idx      (win_idx),
    .ctrl     (ctrl),
    .cmp_all  (cmp_regs),
    .rdata    (bus_rdata)
  );

  assign armed    = ctrl.arm;
  assign dbg_mode = ctrl.mode;
  assign brk_en   = ctrl.brk;
  assign bank_sel = ctrl.sel;

endmodule

// File: rtl/dbg_regbank_chk.sv
module dbg_regbank_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       TOT_W     = 256,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              armed,
  input logic              trig_pulse,
  input logic              dbg_mode,
  input logic              brk_en,
  input logic [1:0]        bank_sel,
  input logic [TOT_W-1:0]  cmp_regs
);

  a_r3_trig_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(bus_wr && bus_addr == CTRL_ADDR && bus_wdata[6]));

  a_r4_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && bus_wr && bus_addr == CTRL_ADDR) |=>
      (armed == $past(bus_wdata[7]) && dbg_mode == $past(bus_wdata[4]) &&
       brk_en == $past(bus_wdata[3]) && bank_sel == $past(bus_wdata[1:0])));

  a_r5_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable({dbg_mode, brk_en}));

  a_r7_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(cmp_regs));

  a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTRL_ADDR) |=>
      (bus_rdata[6] == 1'b0 && bus_rdata[5] == 1'b0 && bus_rdata[2] == 1'b0 &&
       bus_rdata[7] == $past(armed)));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind dbg_regbank dbg_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOT_W(TOT_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .armed(armed), .trig_pulse(trig_pulse), .dbg_mode(dbg_mode),
  .brk_en(brk_en), .bank_sel(bank_sel), .cmp_regs(cmp_regs)
);

// File: tb/sim_dbg_regbank.sv
module sim_dbg_regbank;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   bus_addr, bus_wdata;
  logic         bus_wr, bus_rd;
  logic [7:0]   bus_rdata;
  logic         armed, trig_pulse, dbg_mode, brk_en;
  logic [1:0]   bank_sel;
  logic [255:0] cmp_regs;

  int nchk = 0, nfail = 0;

  // bench model
  logic       m_arm, m_mode, m_brk;
  logic [1:0] m_sel;
  logic [7:0] m_bank [4][8];

  always #2 clk = ~clk;

  dbg_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .armed(armed), .trig_pulse(trig_pulse), .dbg_mode(dbg_mode),
    .brk_en(brk_en), .bank_sel(bank_sel), .cmp_regs(cmp_regs)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h20) return {m_arm, 2'b00, m_mode, m_brk, 1'b0, m_sel};
    if (a >= 8'h28 && a <= 8'h2F) return m_bank[m_sel][a - 8'h28];
    return 8'h00;
  endfunction

  function automatic logic [255:0] exp_cmp();
    logic [255:0] v;
    for (int n = 0; n < 4; n++)
      for (int b = 0; b < 8; b++)
        v[(n*8 + b)*8 +: 8] = m_bank[n][b];
    return v;
  endfunction

  task automatic check_ctrl(input string req);
    chk({armed, dbg_mode, brk_en, bank_sel} == {m_arm, m_mode, m_brk, m_sel}, req,
        {armed, dbg_mode, brk_en, bank_sel}, {m_arm, m_mode, m_brk, m_sel});
  endtask

  task automatic check_cmp(input string req);
    chk(cmp_regs == exp_cmp(), req, cmp_regs, exp_cmp());
  endtask

  // one-cycle write; trig_pulse sampled in the cycle after the edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(trig_pulse == (a == 8'h20 && d[6]), "R3 trigger pulse", trig_pulse,
        (a == 8'h20 && d[6]));
    if (a == 8'h20) begin
      if (!m_arm) begin m_mode = d[4]; m_brk = d[3]; end
      m_arm = d[7]; m_sel = d[1:0];
    end else if (a >= 8'h28 && a <= 8'h2F && !m_arm) begin
      m_bank[m_sel][a - 8'h28] = d;
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    logic [7:0] e;
    e = exp_rd(a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata == e, req, bus_rdata, e);
    chk(trig_pulse == 1'b0, "R3 no pulse on read", trig_pulse, 0);
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_0042));
    m_arm = 0; m_mode = 0; m_brk = 0; m_sel = 0;
    for (int n = 0; n < 4; n++) for (int b = 0; b < 8; b++) m_bank[n][b] = 8'h00;
    bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check_ctrl("R1 ctrl reset");
    check_cmp("R1 comparator reset");
    chk(trig_pulse == 0 && bus_rdata == 0, "R1 pulse/rdata reset",
        {trig_pulse, bus_rdata}, 0);

    // R4 disarmed load, R2 readback format
    wr(8'h20, 8'hFF);            // arm with mode/brk/sel=3, trigger
    check_ctrl("R4 disarmed load");
    rd(8'h20, "R2 ctrl readback reserved/trigger zero");
    // R5 disarm leaves mode/brk
    wr(8'h20, 8'h00);
    check_ctrl("R5 disarm keeps mode/brk");
    chk(dbg_mode == 1 && brk_en == 1, "R5 mode/brk held", {dbg_mode, brk_en}, 2'b11);
    wr(8'h20, 8'h00);
    check_ctrl("R4 second write clears");

    // R6 fill each bank
    for (int n = 0; n < 4; n++) begin
      wr(8'h20, 8'(n));
      for (int b = 0; b < 8; b++) wr(8'h28 + 8'(b), 8'(8'h10*n + b + 1));
    end
    check_cmp("R6 bank layout");

    // R7 armed window write ignored, R8 bank switch while armed
    wr(8'h20, 8'h81);
    wr(8'h2C, 8'hEE);
    check_cmp("R7 armed write ignored");
    rd(8'h2C, "R7 byte unchanged");
    wr(8'h20, 8'h82);
    check_ctrl("R5 sel moves while armed");
    rd(8'h2D, "R8 read other bank while armed");
    wr(8'h20, 8'h18);            // armed: mode/brk blocked, disarms
    check_ctrl("R5 armed mode write blocked");

    // R9 unmapped
    wr(8'h21, 8'hFF);
    wr(8'h30, 8'hAB);
    check_ctrl("R9 unmapped write ctrl");
    check_cmp("R9 unmapped write cmp");
    rd(8'h21, "R9 unmapped read");
    rd(8'h27, "R9 unmapped read below window");

    // R10 idle rdata zero after read
    rd(8'h28, "R8 window read");
    @(negedge clk);
    chk(bus_rdata == 0, "R10 idle rdata", bus_rdata, 0);
    rd(8'h28, "R10 read repeat no side effect");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      r = $urandom;
      case (r[1:0])
        2'd0: wr(8'h20, r[15:8]);
        2'd1: wr(8'h28 + 8'(r[4:2]), r[23:16]);
        2'd2: begin
          case (r[9:8])
            2'd0:    rd(8'h20, "R2 random ctrl read");
            2'd1:    rd(8'h28 + 8'(r[4:2]), "R8 random window read");
            default: rd(r[23:16], "R9 random address read");
          endcase
        end
        default: wr(r[23:16], r[31:24]);
      endcase
      check_ctrl("R5 random ctrl state");
      check_cmp("R7 random comparator state");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule